// File: doc/BRIEF.md
# Per-Source Configurable Interrupt Controller

This block gathers three fault conditions from elsewhere in a mixed-signal device: a clock fault, a converter overflow and a converter underflow. It turns them into a latched status byte and a single active-high interrupt line. Every condition is brought into the local clock domain before anything else looks at it. A small 8-bit register port gives software access to the status byte, an enable (mask) byte and two trigger-mode bytes.

Each source has its own trigger mode. It can fire when its condition appears, fire when its condition goes away, or stay active for as long as the condition holds. A fourth code is reserved and keeps the source silent. Edge-triggered sources leave a sticky status bit that software clears by reading the status register. A level-triggered source shows the live condition. A disabled source can neither set status nor raise the interrupt.

Top module: `irq_gather`

## Requirements
- R1: Register map. Status is at 0x0D and is read-only. Enable is at 0x0E, mode-high at 0x0F and mode-low at 0x10. In every register the clock fault uses bit 3, overflow bit 1 and underflow bit 0. Bits 7..4 and bit 2 always read 0, whatever was written to them. Any other address reads 0x00.
- R2: While reset is active, and after it is released, the enable, both mode registers and the status register read 0x00 and `irq_o` is 0.
- R3: A source whose enable bit is 0 never sets its status bit and never raises `irq_o`. Clearing an enable bit also drops that source's status bit one cycle later, and setting the enable bit again does not bring it back.
- R4: A source's mode is {mode-high bit, mode-low bit} at its own bit position. In mode 00, an absent-to-present change of the condition sets a sticky status bit.
- R5: In mode 01, a present-to-absent change sets the sticky status bit, and the appearance of the condition sets nothing.
- R6: In mode 10, the status bit follows the synchronised condition while the source is enabled, and a status read does not clear it.
- R7: In mode 11, the source never sets status and never raises `irq_o`.
- R8: A status read returns the current value and clears every edge-mode bit at the same clock edge. An edge event that falls on that same edge still leaves its bit set.
- R9: `irq_o` is a flop that holds the OR of all status bits from the previous cycle. It falls one cycle after the last status bit clears.
- R10: Each condition input passes through two synchroniser flops. A change that is set up before edge k shows in status after edge k+2 and on `irq_o` after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clk_err_i | input | 1 | Raw clock-fault condition, asynchronous |
| ovf_i | input | 1 | Raw converter-overflow condition, asynchronous |
| unf_i | input | 1 | Raw converter-underflow condition, asynchronous |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; a status read clears edge bits at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the addressed register while `reg_rd` is high, otherwise 0 |
| irq_o | output | 1 | Active-high interrupt |

## Verification
After a condition input changes, the bench waits four clock edges and then samples on a falling edge. That wait covers the two synchroniser flops, the status flop and the interrupt flop. Register reads are combinational and are sampled just after the address is driven. Because a status read clears its bits at the following rising edge, checks of the interrupt after a read wait two more edges. One directed sequence steps through single cycles. It asserts a status read in the exact cycle that an edge event lands, expects 0 from that read and then 1 from the next read. It also confirms that `irq_o` is still low one edge after status sets and high one edge after that.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int unsigned OFS_STATUS  = 'h0D;
  localparam int unsigned OFS_ENABLE  = 'h0E;
  localparam int unsigned OFS_MODE_HI = 'h0F;
  localparam int unsigned OFS_MODE_LO = 'h10;

  localparam int unsigned BIT_CLK = 3;
  localparam int unsigned BIT_OVF = 1;
  localparam int unsigned BIT_UNF = 0;

  localparam int unsigned SRC_BITS = (1 << BIT_CLK) | (1 << BIT_OVF) | (1 << BIT_UNF);

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_LEVEL = 2'b10,
    TRIG_RSVD  = 2'b11
  } trig_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/irq_cond_sync.sv
module irq_cond_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cond_i,
  input  logic  enable_i,
  input  trig_e mode_i,
  input  logic  rd_clr_i,
  output logic  flag_o
);

  logic prev_q;
  logic flag_q, flag_d;
  logic hit_rise, hit_fall, keep;

  assign hit_rise = cond_i & ~prev_q;
  assign hit_fall = ~cond_i & prev_q;
  assign keep     = flag_q & ~rd_clr_i;

  always_comb begin
    case (mode_i)
      TRIG_RISE:  flag_d = keep | hit_rise;
      TRIG_FALL:  flag_d = keep | hit_fall;
      TRIG_LEVEL: flag_d = cond_i;
      default:    flag_d = 1'b0;
    endcase
    if (!enable_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= cond_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_pkg::*;
#(
  parameter int             AW          = 8,
  parameter int             DW          = 8,
  parameter int             SYNC_STAGES = 2,
  parameter logic [DW-1:0]  SRC_PRESENT = DW'(SRC_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_err_i,
  input  logic          ovf_i,
  input  logic          unf_i,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o
);

  localparam logic [AW-1:0] A_STATUS  = AW'(OFS_STATUS);
  localparam logic [AW-1:0] A_ENABLE  = AW'(OFS_ENABLE);
  localparam logic [AW-1:0] A_MODE_HI = AW'(OFS_MODE_HI);
  localparam logic [AW-1:0] A_MODE_LO = AW'(OFS_MODE_LO);

  logic          rst_n_sync;
  logic [DW-1:0] cond_raw, cond_s;
  logic [DW-1:0] mask_q, mode_hi_q, mode_lo_q;
  logic [DW-1:0] mask_d, mode_hi_d, mode_lo_d;
  logic          mask_en, mode_hi_en, mode_lo_en;
  logic [DW-1:0] status;
  logic          sel_status, sel_enable, sel_mode_hi, sel_mode_lo;
  logic          rd_clr;
  logic          irq_q, irq_d;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_sync)
  );

  always_comb begin
    cond_raw          = '0;
    cond_raw[BIT_CLK] = clk_err_i;
    cond_raw[BIT_OVF] = ovf_i;
    cond_raw[BIT_UNF] = unf_i;
  end

  irq_cond_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .d_i   (cond_raw),
    .q_o   (cond_s)
  );

  assign sel_status  = (reg_addr == A_STATUS);
  assign sel_enable  = (reg_addr == A_ENABLE);
  assign sel_mode_hi = (reg_addr == A_MODE_HI);
  assign sel_mode_lo = (reg_addr == A_MODE_LO);
  assign rd_clr      = reg_rd & sel_status;

  assign mask_en    = reg_wr & sel_enable;
  assign mode_hi_en = reg_wr & sel_mode_hi;
  assign mode_lo_en = reg_wr & sel_mode_lo;
  assign mask_d     = reg_wdata & SRC_PRESENT;
  assign mode_hi_d  = reg_wdata & SRC_PRESENT;
  assign mode_lo_d  = reg_wdata & SRC_PRESENT;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      mask_q    <= '0;
      mode_hi_q <= '0;
      mode_lo_q <= '0;
    end else begin
      if (mask_en)    mask_q    <= mask_d;
      if (mode_hi_en) mode_hi_q <= mode_hi_d;
      if (mode_lo_en) mode_lo_q <= mode_lo_d;
    end
  end

  for (genvar i = 0; i < DW; i++) begin : g_src
    irq_src_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .cond_i   (cond_s[i]),
      .enable_i (mask_q[i] & SRC_PRESENT[i]),
      .mode_i   (trig_e'({mode_hi_q[i], mode_lo_q[i]})),
      .rd_clr_i (rd_clr),
      .flag_o   (status[i])
    );
  end

  assign irq_d = |status;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (sel_status)       reg_rdata = status;
      else if (sel_enable)  reg_rdata = mask_q;
      else if (sel_mode_hi) reg_rdata = mode_hi_q;
      else if (sel_mode_lo) reg_rdata = mode_lo_q;
    end
  end

endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk
  import irq_pkg::*;
#(
  parameter int            AW          = 8,
  parameter int            DW          = 8,
  parameter logic [DW-1:0] SRC_PRESENT = DW'(SRC_BITS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] mode_hi_q,
  input logic [DW-1:0] mode_lo_q,
  input logic [DW-1:0] status,
  input logic [DW-1:0] cond_s,
  input logic          irq_o,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_rdata
);

  localparam logic [AW-1:0] A_STATUS = AW'(OFS_STATUS);

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_STATUS) |-> ((reg_rdata & ~SRC_PRESENT) == '0)); // R1

  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(mask_q)) == '0)); // R3

  AST_RSVD_MODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(mode_hi_q & mode_lo_q)) == '0)); // R7

  AST_LEVEL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(mode_hi_q & ~mode_lo_q)) ==
              $past(cond_s & mask_q & mode_hi_q & ~mode_lo_q))); // R6

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(reg_rd && reg_addr == A_STATUS) ||
              (($past(status & mask_q & ~mode_hi_q) & ~status) == '0))); // R8

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|status))); // R9

endmodule

bind irq_gather irq_gather_chk #(
  .AW(AW), .DW(DW), .SRC_PRESENT(SRC_PRESENT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .mask_q    (mask_q),
  .mode_hi_q (mode_hi_q),
  .mode_lo_q (mode_lo_q),
  .status    (status),
  .cond_s    (cond_s),
  .irq_o     (irq_o),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata)
);

// File: tb/irq_gather_test.sv
`timescale 1ns/1ps
module irq_gather_test;

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_CND = 2'd2, K_IRQ = 2'd3;
  localparam int NV = 50;

  // {kind, addr, data, expected, requirement number}
  localparam logic [29:0] VEC [NV] = '{
    {K_RD,  8'h0D, 8'h00, 8'h00, 4'd2},   // R2 status after reset
    {K_RD,  8'h0E, 8'h00, 8'h00, 4'd2},   // R2 enable after reset
    {K_RD,  8'h0F, 8'h00, 8'h00, 4'd2},   // R2 mode-high after reset
    {K_RD,  8'h10, 8'h00, 8'h00, 4'd2},   // R2 mode-low after reset
    {K_IRQ, 8'h00, 8'h00, 8'h00, 4'd2},   // R2 irq low
    {K_WR,  8'h0E, 8'hFF, 8'h00, 4'd1},
    {K_RD,  8'h0E, 8'h00, 8'h0B, 4'd1},   // R1 reserved enable bits read 0
    {K_RD,  8'h20, 8'h00, 8'h00, 4'd1},   // R1 unmapped address
    {K_WR,  8'h0F, 8'hF7, 8'h00, 4'd1},
    {K_RD,  8'h0F, 8'h00, 8'h03, 4'd1},   // R1 mode-high reserved bits
    {K_WR,  8'h0F, 8'h00, 8'h00, 4'd1},
    {K_CND, 8'h00, 8'h01, 8'h00, 4'd4},   // underflow appears, mode 00
    {K_IRQ, 8'h00, 8'h00, 8'h01, 4'd9},   // R9 irq raised
    {K_RD,  8'h0D, 8'h00, 8'h01, 4'd4},   // R4 sticky rising bit
    {K_IRQ, 8'h00, 8'h00, 8'h00, 4'd8},   // R8 cleared by read
    {K_RD,  8'h0D, 8'h00, 8'h00, 4'd8},   // R8 stays clear with condition held
    {K_CND, 8'h00, 8'h00, 8'h00, 4'd4},
    {K_RD,  8'h0D, 8'h00, 8'h00, 4'd4},   // R4 removal ignored in mode 00
    {K_WR,  8'h10, 8'h02, 8'h00, 4'd5},   // overflow mode 01
    {K_CND, 8'h00, 8'h02, 8'h00, 4'd5},
    {K_RD,  8'h0D, 8'h00, 8'h00, 4'd5},   // R5 appearance ignored
    {K_CND, 8'h00, 8'h00, 8'h00, 4'd5},
    {K_RD,  8'h0D, 8'h00, 8'h02, 4'd5},   // R5 removal latched
    {K_WR,  8'h0F, 8'h08, 8'h00, 4'd6},   // clock fault mode 10
    {K_CND, 8'h00, 8'h08, 8'h00, 4'd6},
    {K_RD,  8'h0D, 8'h00, 8'h08, 4'd6},   // R6 level visible
    {K_RD,  8'h0D, 8'h00, 8'h08, 4'd6},   // R6 not cleared by read
    {K_IRQ, 8'h00, 8'h00, 8'h01, 4'd6},   // R6 irq while level held
    {K_CND, 8'h00, 8'h00, 8'h00, 4'd6},
    {K_RD,  8'h0D, 8'h00, 8'h00, 4'd6},   // R6 follows removal
    {K_IRQ, 8'h00, 8'h00, 8'h00, 4'd9},   // R9 irq falls
    {K_WR,  8'h10, 8'h0A, 8'h00, 4'd7},   // clock fault mode 11
    {K_CND, 8'h00, 8'h08, 8'h00, 4'd7},
    {K_RD,  8'h0D, 8'h00, 8'h00, 4'd7},   // R7 reserved mode silent
    {K_IRQ, 8'h00, 8'h00, 8'h00, 4'd7},   // R7 no irq
    {K_CND, 8'h00, 8'h00, 8'h00, 4'd7},
    {K_RD,  8'h0D, 8'h00, 8'h00, 4'd7},   // R7 no falling latch either
    {K_WR,  8'h0F, 8'h00, 8'h00, 4'd3},
    {K_WR,  8'h10, 8'h00, 8'h00, 4'd3},
    {K_WR,  8'h0E, 8'h0A, 8'h00, 4'd3},   // underflow disabled
    {K_CND, 8'h00, 8'h01, 8'h00, 4'd3},
    {K_RD,  8'h0D, 8'h00, 8'h00, 4'd3},   // R3 disabled source no status
    {K_IRQ, 8'h00, 8'h00, 8'h00, 4'd3},   // R3 disabled source no irq
    {K_CND, 8'h00, 8'h00, 8'h00, 4'd3},
    {K_WR,  8'h0E, 8'h0B, 8'h00, 4'd3},
    {K_RD,  8'h0D, 8'h00, 8'h00, 4'd3},   // R3 missed event not replayed
    {K_CND, 8'h00, 8'h0B, 8'h00, 4'd4},
    {K_RD,  8'h0D, 8'h00, 8'h0B, 4'd4},   // R4 all three at once
    {K_CND, 8'h00, 8'h00, 8'h00, 4'd4},
    {K_RD,  8'h0D, 8'h00, 8'h00, 4'd4}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clk_err_i, ovf_i, unf_i;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr, reg_rd, irq_o;
  int         n_vec = 0, n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  irq_gather uut (
    .clk(clk), .rst_n(rst_n), .clk_err_i(clk_err_i), .ovf_i(ovf_i), .unf_i(unf_i),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a; reg_rd = 1'b1;
    #1 check(req, reg_rdata, exp);
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_cond(input logic [7:0] c);
    clk_err_i = c[3]; ovf_i = c[1]; unf_i = c[0];
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; clk_err_i = 0; ovf_i = 0; unf_i = 0;
    reg_addr = '0; reg_wdata = '0; reg_wr = 0; reg_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      automatic logic [1:0] k   = VEC[i][29:28];
      automatic logic [7:0] a   = VEC[i][27:20];
      automatic logic [7:0] d   = VEC[i][19:12];
      automatic logic [7:0] e   = VEC[i][11:4];
      automatic string      req = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      case (k)
        K_WR:    do_wr(a, d);
        K_RD:    do_rd(req, a, e);
        K_CND:   set_cond(d);
        default: begin
          repeat (2) @(posedge clk);
          @(negedge clk);
          check(req, {7'b0, irq_o}, e);
        end
      endcase
    end

    // R8 / R10: read lands in the same cycle as an underflow rising edge
    unf_i = 1'b1;
    @(posedge clk);                       // edge k: first sync flop
    @(posedge clk);                       // edge k+1: second sync flop
    @(negedge clk);
    do_rd("R10 status not before k+2", 8'h0D, 8'h00); // read spans edge k+2
    check("R10 irq one edge after status", {7'b0, irq_o}, 8'h00);
    do_rd("R8 event kept across clearing read", 8'h0D, 8'h01); // spans k+3
    check("R10 irq at k+3", {7'b0, irq_o}, 8'h01);
    @(posedge clk); @(negedge clk);
    check("R9 irq falls after clear", {7'b0, irq_o}, 8'h00);
    set_cond(8'h00);

    // R3: disabling drops a latched bit, re-enabling does not restore it
    set_cond(8'h02);
    check("R3 overflow latched first", {7'b0, irq_o}, 8'h01);
    do_wr(8'h0E, 8'h09);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R3 irq gone after disable", {7'b0, irq_o}, 8'h00);
    do_rd("R3 status gone after disable", 8'h0D, 8'h00);
    do_wr(8'h0E, 8'h0B);
    do_rd("R3 not restored on re-enable", 8'h0D, 8'h00);
    set_cond(8'h00);

    // R2: reset in the middle of operation
    set_cond(8'h01);
    check("R2 irq high before reset", {7'b0, irq_o}, 8'h01);
    rst_n = 1'b0;
    reg_addr = 8'h0E; reg_rd = 1'b1;
    #1 check("R2 enable cleared by reset", reg_rdata, 8'h00);
    check("R2 irq cleared by reset", {7'b0, irq_o}, 8'h00);
    reg_rd = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    set_cond(8'h00);
    do_rd("R2 status after reset", 8'h0D, 8'h00);
    do_rd("R2 mode-low after reset", 8'h10, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule